// File: doc/BRIEF.md
# Push-Pull PWM Controller Core

This block is a digital pulse-width modulation controller for a two-switch push-pull power stage. A free-running ramp counter defines the switching period. A phase flip-flop hands alternate periods to output A and output B. A set-only pulse latch ends each pulse when the counter reaches the compare threshold, and a blanking window at the end of every ramp forces both outputs low to form the deadtime. Each output is active high and idles low.

The compare threshold is the smaller of the duty command and an internal soft-start value. The soft-start value climbs from zero after reset. A shutdown request kills the pulse in flight at once and drains the soft-start value once per period. A short request therefore clips only one pulse, while a held request forces a fresh slow start.

An undervoltage flag holds both outputs low and freezes the soft-start value. A rising edge on the sync input restarts the ramp, so the controller can follow an external clock or a second controller. The shutdown and sync inputs pass through two-flop synchronizers. The undervoltage flag gates the outputs directly.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: After reset, both outputs stay low for the whole first period. The phase selects output A first, the pulse latch is set and the soft-start value is zero.
- R2: Outputs A and B are never high together. Successive pulses alternate between A and B, one period each.
- R3: In steady state each output is high for min(duty_i, soft-start, PERIOD-1-deadtime_i) cycles per two periods. The pulse starts at ramp count 0. duty_i = 0 gives no pulse.
- R4: Both outputs are low for the last deadtime_i+1 counts of every period, so duty per output stays below 50% of the two-period cycle.
- R5: Once a pulse has ended inside a period, the output stays low until the next period, even if the threshold rises again.
- R6: A shutdown_i level, seen two clock edges later, forces both outputs low at once. It keeps them low for as long as it is held and until the end of the period in which it ends.
- R7: A shutdown request that lasts less than a period and falls within one period does not lower the soft-start value. Full-width pulses resume in the next period.
- R8: While the synchronized shutdown is held, the soft-start value drops by DRAIN_STEP, saturating at zero, at every period boundary. After a long shutdown the first pulse is 1 cycle wide.
- R9: Without shutdown or undervoltage, the soft-start value rises by one, saturating at its maximum, once every ss_div_i+1 periods.
- R10: While uv_i is high, both outputs are low and the soft-start value does not change.
- R11: A rising edge on sync_i restarts the ramp count at 0 and flips the phase. The newly selected output rises three cycles after sync_i goes high.
- R12: Without sync, the ramp repeats every PERIOD cycles, so rises of successive pulses are PERIOD cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | DUTY_W | Duty command in ramp counts |
| deadtime_i | input | DT_W | Extra blanking counts at the end of each ramp |
| ss_div_i | input | DIV_W | Soft-start rises once per ss_div_i+1 periods |
| sync_i | input | 1 | Ramp restart on rising edge |
| shutdown_i | input | 1 | Asynchronous shutdown request, active high |
| uv_i | input | 1 | Undervoltage flag, active high |
| out_a | output | 1 | Push-pull output A, active high |
| out_b | output | 1 | Push-pull output B, active high |

## Verification
The bench lowers the duty command in the middle of a pulse and raises it again. A design without a holding latch would then fire a second pulse in the same period. It counts the exact pulse width left after a two-cycle shutdown. A missing synchronizer stage or a latch set one cycle late would show up as a wrong width there, and a design that drained the soft-start value on every cycle would lose the full width that should follow. After long shutdowns and undervoltage, it tracks the widths of successive pulses. A ramp that charges while locked out, or that steps at the wrong interval, gives a first pulse wider than one cycle or a wrong staircase. It also fires sync during the off time, where a design that ignores sync, or restarts without flipping the phase, leaves the wrong output low.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  // phase of the push-pull pair; PH_A enables output A
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;
endpackage

// File: rtl/pp_sync2.sv
module pp_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        hold_q <= meta_q;
      end
    end
    assign q_o[i] = hold_q;
  end
endmodule

// File: rtl/pp_ramp.sv
module pp_ramp #(
  parameter int PERIOD = 32,
  parameter int CNT_W  = 5,
  parameter int DT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [DT_W-1:0]  dt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             blank_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  // blanking covers the last dt+1 counts of the ramp
  function automatic logic in_blank(input logic [CNT_W-1:0] c, input logic [DT_W-1:0] d);
    return c >= (LAST - CNT_W'(d));
  endfunction

  assign wrap_o  = restart_i | (cnt_q == LAST);
  assign blank_o = in_blank(cnt_q, dt_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  a_r12_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r12_period_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> cnt_q == '0);
endmodule

// File: rtl/pp_softstart.sv
module pp_softstart #(
  parameter int SS_W  = 8,
  parameter int DIV_W = 4,
  parameter int DRAIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic             drain_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [SS_W-1:0]  ss_o
);
  localparam logic [SS_W-1:0] TOP     = {SS_W{1'b1}};
  localparam logic [SS_W-1:0] DRAIN_V = SS_W'(DRAIN);

  logic [SS_W-1:0]  ss_q;
  logic [DIV_W-1:0] div_q;

  function automatic logic [SS_W-1:0] step_up(input logic [SS_W-1:0] v);
    return (v == TOP) ? v : v + SS_W'(1);
  endfunction

  function automatic logic [SS_W-1:0] step_down(input logic [SS_W-1:0] v);
    return (v > DRAIN_V) ? v - DRAIN_V : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q  <= '0;
      div_q <= '0;
    end else if (wrap_i) begin
      if (drain_i) begin
        ss_q  <= step_down(ss_q);
        div_q <= '0;
      end else if (hold_i) begin
        div_q <= '0;
      end else if (div_q >= div_i) begin
        ss_q  <= step_up(ss_q);
        div_q <= '0;
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign ss_o = ss_q;

  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_i |=> ({1'b0, ss_q} <= {1'b0, $past(ss_q)} + (SS_W+1)'(1)));
  a_r10_hold_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !drain_i) |=> ss_q == $past(ss_q));
  a_r8_drain_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |=> ss_q <= $past(ss_q));
endmodule

// File: rtl/pp_steer.sv
module pp_steer
  import pp_pwm_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic             blank_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             shdn_i,
  input  logic             uv_i,
  output logic             out_a_o,
  output logic             out_b_o
);
  localparam int CMP_W = (THR_W > CNT_W) ? THR_W : CNT_W;

  phase_e phase_q;
  logic   latch_q;
  logic   cmp_hit;
  logic   pulse_off;

  assign cmp_hit   = CMP_W'(cnt_i) >= CMP_W'(thr_i);
  assign pulse_off = latch_q | cmp_hit | shdn_i | uv_i;
  assign out_a_o   = ~(blank_i | (phase_q != PH_A) | pulse_off);
  assign out_b_o   = ~(blank_i | (phase_q != PH_B) | pulse_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b1;
      phase_q <= PH_A;
    end else begin
      if (shdn_i)       latch_q <= 1'b1;
      else if (wrap_i)  latch_q <= 1'b0;
      else if (cmp_hit) latch_q <= 1'b1;
      if (wrap_i) phase_q <= (phase_q == PH_A) ? PH_B : PH_A;
    end
  end

  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !wrap_i) |=> latch_q);
  a_r2_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> phase_q != $past(phase_q));
  a_r4_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |-> (!out_a_o && !out_b_o));
  a_r10_uv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |-> (!out_a_o && !out_b_o));
  a_r6_shdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_i |-> (!out_a_o && !out_b_o));
endmodule

// File: rtl/pp_pwm_ctrl.sv
module pp_pwm_ctrl #(
  parameter int PERIOD     = 32,
  parameter int DUTY_W     = 8,
  parameter int DT_W       = 3,
  parameter int DIV_W      = 4,
  parameter int DRAIN_STEP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DT_W-1:0]   deadtime_i,
  input  logic [DIV_W-1:0]  ss_div_i,
  input  logic              sync_i,
  input  logic              shutdown_i,
  input  logic              uv_i,
  output logic              out_a,
  output logic              out_b
);
  localparam int CNT_W = $clog2(PERIOD);

  logic              sync_s, shdn_s, sync_d, restart;
  logic [CNT_W-1:0]  cnt;
  logic              wrap, blank;
  logic [DUTY_W-1:0] ss, thr;

  function automatic logic [DUTY_W-1:0] eff_threshold(input logic [DUTY_W-1:0] d,
                                                      input logic [DUTY_W-1:0] s);
    return (d < s) ? d : s;
  endfunction

  pp_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sync_i, shutdown_i}),
    .q_o({sync_s, shdn_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_d <= 1'b0;
    else        sync_d <= sync_s;
  end

  assign restart = sync_s & ~sync_d;
  assign thr     = eff_threshold(duty_i, ss);

  pp_ramp #(.PERIOD(PERIOD), .CNT_W(CNT_W), .DT_W(DT_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .dt_i(deadtime_i),
    .cnt_o(cnt), .wrap_o(wrap), .blank_o(blank)
  );

  pp_softstart #(.SS_W(DUTY_W), .DIV_W(DIV_W), .DRAIN(DRAIN_STEP)) u_ss (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .drain_i(shdn_s), .hold_i(uv_i),
    .div_i(ss_div_i), .ss_o(ss)
  );

  pp_steer #(.CNT_W(CNT_W), .THR_W(DUTY_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .blank_i(blank), .cnt_i(cnt),
    .thr_i(thr), .shdn_i(shdn_s), .uv_i(uv_i), .out_a_o(out_a), .out_b_o(out_b)
  );

  a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));
  a_r11_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
  a_r3_threshold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a || out_b) |-> ({{(DUTY_W > CNT_W ? DUTY_W - CNT_W : 0){1'b0}}, cnt} < thr));
endmodule

// File: tb/pp_pwm_ctrl_test.sv
`timescale 1ns/1ps
module pp_pwm_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] duty = 8'd200;
  logic [2:0] dt = 3'd0;
  logic [3:0] ssdiv = 4'd0;
  logic       sync = 1'b0, shdn = 1'b0, uv = 1'b0;
  wire        out_a, out_b;

  int n_chk = 0;
  int n_err = 0;
  int pw[16];
  int pwho[16];
  int prise[16];

  always #4 clk = ~clk;

  pp_pwm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .duty_i(duty), .deadtime_i(dt), .ss_div_i(ssdiv),
    .sync_i(sync), .shutdown_i(shdn), .uv_i(uv), .out_a(out_a), .out_b(out_b)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic reset_dut(bit uv_on);
    @(negedge clk);
    rst_n = 1'b0; uv = uv_on; shdn = 1'b0; sync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic window(output int ca, output int cb, output int ov);
    ca = 0; cb = 0; ov = 0;
    repeat (64) begin
      @(negedge clk);
      if (out_a) ca++;
      if (out_b) cb++;
      if (out_a && out_b) ov++;
    end
  endtask

  task automatic capture(int n);
    int t = 0;
    while (out_a || out_b) begin @(negedge clk); t++; end
    for (int k = 0; k < n; k++) begin
      while (!(out_a || out_b)) begin @(negedge clk); t++; end
      prise[k] = t;
      pwho[k]  = out_a ? 0 : 1;
      pw[k]    = 0;
      while (out_a || out_b) begin pw[k]++; @(negedge clk); t++; end
    end
  endtask

  task automatic t_reset();
    int hi = 0;
    reset_dut(1'b0);
    repeat (31) begin
      @(negedge clk);
      if (out_a || out_b) hi++;
    end
    chk("R1", "high cycles in first period", hi, 0);
    repeat (1280) @(negedge clk);
  endtask

  task automatic steady(int d, int t, int exp);
    int ca, cb, ov;
    duty = 8'(d); dt = 3'(t);
    repeat (64) @(negedge clk);
    window(ca, cb, ov);
    chk("R3", $sformatf("A width duty=%0d dt=%0d", d, t), ca, exp);
    chk("R4", $sformatf("B width duty=%0d dt=%0d", d, t), cb, exp);
    chk("R2", "overlap cycles", ov, 0);
  endtask

  task automatic t_latch();
    int hi = 1, extra = 0;
    duty = 8'd200; dt = 3'd0;
    repeat (64) @(negedge clk);
    while (out_a || out_b) @(negedge clk);
    while (!(out_a || out_b)) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (out_a || out_b) hi++;
    end
    duty = 8'd2;
    @(negedge clk);
    duty = 8'd200;
    repeat (26) begin
      @(negedge clk);
      if (out_a || out_b) extra++;
    end
    chk("R5", "width before duty drop", hi, 5);
    chk("R5", "high cycles after threshold rose again", extra, 0);
  endtask

  task automatic t_sync();
    int who, q = 0;
    duty = 8'd200; dt = 3'd7;
    repeat (64) @(negedge clk);
    while (out_a || out_b) @(negedge clk);
    while (!(out_a || out_b)) @(negedge clk);
    who = out_a ? 0 : 1;
    while (out_a || out_b) @(negedge clk);
    sync = 1'b1;
    @(negedge clk);
    if (out_a || out_b) q++;
    @(negedge clk);
    if (out_a || out_b) q++;
    sync = 1'b0;
    @(negedge clk);
    chk("R11", "high cycles before restart", q, 0);
    chk("R11", "new phase output high 3 cycles after sync", (who == 0) ? int'(out_b) : int'(out_a), 1);
    chk("R11", "old phase output low after sync", (who == 0) ? int'(out_a) : int'(out_b), 0);
  endtask

  task automatic t_short_shdn();
    int hi = 1, ca, cb, ov;
    duty = 8'd200; dt = 3'd0;
    repeat (64) @(negedge clk);
    while (out_a || out_b) @(negedge clk);
    while (!(out_a || out_b)) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (out_a || out_b) hi++;
    end
    shdn = 1'b1;
    repeat (2) begin
      @(negedge clk);
      if (out_a || out_b) hi++;
    end
    shdn = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (out_a || out_b) hi++;
    end
    chk("R6", "pulse width cut by shutdown", hi, 5);
    repeat (64) @(negedge clk);
    window(ca, cb, ov);
    chk("R7", "A full width after short shutdown", ca, 31);
    chk("R7", "B full width after short shutdown", cb, 31);
  endtask

  task automatic t_long_shdn();
    int ca, cb, ov;
    duty = 8'd200; dt = 3'd7; ssdiv = 4'd0;
    shdn = 1'b1;
    repeat (1216) @(negedge clk);
    window(ca, cb, ov);
    chk("R6", "high cycles during held shutdown", ca + cb, 0);
    shdn = 1'b0;
    capture(5);
    for (int k = 0; k < 5; k++) chk("R8", $sformatf("restart pulse %0d width", k), pw[k], k + 1);
    chk("R12", "rise spacing", prise[1] - prise[0], 32);
    chk("R2", "alternating outputs", int'(pwho[1] != pwho[0]) + int'(pwho[2] != pwho[1]), 2);
    shdn = 1'b1; ssdiv = 4'd3;
    repeat (1280) @(negedge clk);
    shdn = 1'b0;
    capture(9);
    chk("R9", "div=3 pulse 0 width", pw[0], 1);
    chk("R9", "div=3 pulse 3 width", pw[3], 1);
    chk("R9", "div=3 pulse 4 width", pw[4], 2);
    chk("R9", "div=3 pulse 8 width", pw[8], 3);
    chk("R12", "rise spacing at div=3", prise[8] - prise[4], 128);
  endtask

  task automatic t_uv();
    int ca, cb, ov;
    duty = 8'd200; dt = 3'd7; ssdiv = 4'd0;
    repeat (64) @(negedge clk);
    uv = 1'b1;
    window(ca, cb, ov);
    chk("R10", "high cycles under lockout", ca + cb, 0);
    reset_dut(1'b1);
    repeat (640) @(negedge clk);
    window(ca, cb, ov);
    chk("R10", "high cycles under lockout after reset", ca + cb, 0);
    uv = 1'b0;
    capture(2);
    chk("R10", "first pulse after lockout", pw[0], 1);
    chk("R10", "second pulse after lockout", pw[1], 2);
  endtask

  initial begin
    t_reset();
    steady(0, 0, 0);
    steady(5, 0, 5);
    steady(17, 0, 17);
    steady(31, 0, 31);
    steady(200, 0, 31);
    steady(200, 3, 28);
    steady(26, 7, 24);
    steady(10, 7, 10);
    t_latch();
    t_sync();
    t_short_shdn();
    t_long_shdn();
    t_uv();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule